// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block holds the stores that a strand produces while it runs speculatively. Such stores never reach memory directly. Each one goes into a small in-order queue, together with its word address, its write data, its byte-enable mask and an epoch bit. The epoch bit records whether an older "behind" strand or a younger "ahead" strand issued the store.

Two load-lookup ports search the queue in the same cycle. One port serves the behind strand and one serves the ahead strand. Each port returns read-after-write bypass data from the stores its strand is allowed to see. If the queued stores cover only some of the bytes a load asks for, the port raises a conflict flag and returns no data.

Two control pulses end speculation. `spec_join` commits the buffered stores: they drain to a memory write port in enqueue order over a valid/ready handshake. `spec_fail` throws every buffered store away in a single cycle.

The store-enqueue port is valid/ready. A store is taken on a clock edge where both `enq_valid` and `enq_ready` are high. `enq_ready` is low while the queue is full and for as long as a drain is in progress. The memory write port follows the same rule: a store is retired on an edge where both `mem_valid` and `mem_ready` are high. While `mem_ready` is low, `mem_valid` and the presented store hold steady.

Top module: `spec_store_buf`

## Requirements
- R1: After reset the queue is empty: `mem_valid`=0, `full`=0, `enq_ready`=1, and both lookup ports report no hit, no conflict and data 0.
- R2: While no join is in progress, `mem_valid` stays 0 regardless of how many stores are queued. `mem_valid` can only rise in the cycle after `spec_join` is sampled high.
- R3: When `spec_fail` is sampled high and no drain is in progress, every queued store is discarded by the next cycle. A store enqueued in the same cycle is discarded too. `spec_fail` wins over a simultaneous `spec_join`, and nothing is later written to memory.
- R4: A `spec_join` sampled with at least one store queued starts a drain. During the drain, stores appear on `mem_addr`/`mem_data`/`mem_mask` oldest first, one per handshake. The presented store and `mem_valid` stay unchanged while `mem_ready` is low.
- R5: `full` is 1 exactly when DEPTH stores are queued. `enq_ready` is 0 while full or while draining. An enqueue offered while `enq_ready` is 0 is ignored and is never forwarded or written.
- R6: Lookup port index 0 (behind) forwards only from stores enqueued with epoch 0. Port index 1 (ahead) forwards from stores of both epochs. Stores still queued during a drain remain visible to lookups.
- R7: A lookup matches a queued store when the full word address is equal. Mask bit b selects data bits 8b+7..8b. Each requested byte is taken from the youngest eligible matching store that writes that byte, so bytes from different stores are merged.
- R8: If eligible matching stores cover some but not all of the requested bytes, the port reports conflict=1, hit=0 and data 0. If they cover none, it reports hit=0, conflict=0 and data 0.
- R9: During a drain, `spec_fail` and further `spec_join` pulses are ignored, and every committed store is still written to memory.
- R10: When the last store of a drain is accepted, the queue returns to speculative operation with `enq_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Store offered on the enqueue port |
| enq_ready | output | 1 | Queue can accept a store this cycle |
| enq_addr | input | AW | Word address of the store |
| enq_data | input | DW | Store data |
| enq_mask | input | DW/8 | Byte enables of the store |
| enq_epoch | input | 1 | 0 = behind strand, 1 = ahead strand |
| ld_addr | input | 2 x AW | Lookup word address per port (index 0 behind, 1 ahead) |
| ld_mask | input | 2 x DW/8 | Requested bytes per lookup port |
| ld_hit | output | 2 | All requested bytes forwarded |
| ld_conflict | output | 2 | Requested bytes only partly covered |
| ld_data | output | 2 x DW | Forwarded data per port |
| spec_join | input | 1 | Commit pulse: drain queued stores |
| spec_fail | input | 1 | Abort pulse: discard queued stores |
| mem_valid | output | 1 | Committed store presented to memory |
| mem_ready | input | 1 | Memory accepts the presented store |
| mem_addr | output | AW | Address of the presented store |
| mem_data | output | DW | Data of the presented store |
| mem_mask | output | DW/8 | Byte enables of the presented store |
| full | output | 1 | DEPTH stores are queued |

## Verification
The bench goes after epoch filtering. A buffer that ignored the epoch would hand ahead-strand data to the behind port. It also goes after per-byte merging across two stores to one word. A design that picked a whole entry instead of individual bytes would return a stale byte, and one that merged partial coverage would return data where a conflict is due.

A store offered while the queue is full is looked up afterwards. If the design overwrote an entry instead of refusing the store, that lookup exposes it. A pulse of `spec_fail` is given in the middle of a stalled drain. A design that honoured it would lose committed stores, and the scoreboard would see the drain end early. A `spec_join` and a `spec_fail` in the same cycle must produce no memory write at all. A mistake in the read pointer's wrap-around would show up as out-of-order memory writes once the queue has cycled several times.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  typedef enum logic {
    SSB_SPEC  = 1'b0,
    SSB_DRAIN = 1'b1
  } ssb_state_e;

  localparam int SSB_NUM_LD = 2;
endpackage

// File: rtl/ssb_store.sv
module ssb_store #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int BW   = DW / 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic [BW-1:0]             wr_mask,
  input  logic                      wr_epoch,
  input  logic                      pop,
  input  logic                      flush,
  output logic [CW-1:0]             cnt,
  output logic [DEPTH-1:0]          ord_live,
  output logic [DEPTH-1:0][AW-1:0]  ord_addr,
  output logic [DEPTH-1:0][DW-1:0]  ord_data,
  output logic [DEPTH-1:0][BW-1:0]  ord_mask,
  output logic [DEPTH-1:0]          ord_epoch
);
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic [DEPTH-1:0][BW-1:0] mask_q;
  logic [DEPTH-1:0]         ep_q;
  logic [PW-1:0]            head_q, tail_q;
  logic [CW-1:0]            cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      mask_q <= '0;
      ep_q   <= '0;
    end else if (flush) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_en) begin
        addr_q[tail_q] <= wr_addr;
        data_q[tail_q] <= wr_data;
        mask_q[tail_q] <= wr_mask;
        ep_q[tail_q]   <= wr_epoch;
        tail_q         <= bump(tail_q);
      end
      if (pop) head_q <= bump(head_q);
      case ({wr_en, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt = cnt_q;

  // Present slots in age order: position 0 is the oldest store.
  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    logic [PW:0]   sum;
    logic [PW-1:0] idx;
    always_comb begin
      sum = {1'b0, head_q} + (PW + 1)'(k);
      idx = (sum >= (PW + 1)'(DEPTH)) ? PW'(sum - (PW + 1)'(DEPTH)) : PW'(sum);
    end
    assign ord_live[k]  = CW'(k) < cnt_q;
    assign ord_addr[k]  = addr_q[idx];
    assign ord_data[k]  = data_q[idx];
    assign ord_mask[k]  = mask_q[idx];
    assign ord_epoch[k] = ep_q[idx];
  end
endmodule

// File: rtl/ssb_fwd.sv
module ssb_fwd #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int EPOCH = 0,
  localparam int BW   = DW / 8
) (
  input  logic [DEPTH-1:0]          ord_live,
  input  logic [DEPTH-1:0][AW-1:0]  ord_addr,
  input  logic [DEPTH-1:0][DW-1:0]  ord_data,
  input  logic [DEPTH-1:0][BW-1:0]  ord_mask,
  input  logic [DEPTH-1:0]          ord_epoch,
  input  logic [AW-1:0]             q_addr,
  input  logic [BW-1:0]             q_mask,
  output logic                      hit,
  output logic                      conflict,
  output logic [DW-1:0]             data
);
  localparam logic MY_EP = 1'(EPOCH);

  logic [BW-1:0] covered;
  logic [DW-1:0] merged;
  logic          any_cov, all_cov;

  // Walk oldest to youngest so the youngest writer of each byte wins.
  always_comb begin
    covered = '0;
    merged  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (ord_live[k] && (ord_addr[k] == q_addr) && (ord_epoch[k] <= MY_EP)) begin
        for (int b = 0; b < BW; b++) begin
          if (ord_mask[k][b] && q_mask[b]) begin
            covered[b]       = 1'b1;
            merged[b*8 +: 8] = ord_data[k][b*8 +: 8];
          end
        end
      end
    end
    any_cov  = |covered;
    all_cov  = (covered == q_mask);
    hit      = any_cov && all_cov;
    conflict = any_cov && !all_cov;
    data     = hit ? merged : '0;
  end
endmodule

// File: rtl/ssb_ctrl.sv
module ssb_ctrl
  import ssb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          join_i,
  input  logic          fail_i,
  input  logic          enq_valid,
  input  logic [CW-1:0] cnt,
  input  logic          pop,
  output logic          enq_ready,
  output logic          wr_en,
  output logic          flush,
  output logic          draining
);
  ssb_state_e state_q, state_d;
  logic       enq_fire;

  assign enq_ready = (state_q == SSB_SPEC) && (cnt != CW'(DEPTH));
  assign enq_fire  = enq_valid && enq_ready;
  assign flush     = fail_i && (state_q == SSB_SPEC);
  assign wr_en     = enq_fire && !flush;
  assign draining  = (state_q == SSB_DRAIN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SSB_SPEC:  if (join_i && !fail_i && ((cnt != '0) || enq_fire)) state_d = SSB_DRAIN;
      SSB_DRAIN: if (pop && (cnt == CW'(1))) state_d = SSB_SPEC;
      default:   state_d = SSB_SPEC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SSB_SPEC;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf
  import ssb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int BW   = DW / 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            enq_valid,
  output logic                            enq_ready,
  input  logic [AW-1:0]                   enq_addr,
  input  logic [DW-1:0]                   enq_data,
  input  logic [BW-1:0]                   enq_mask,
  input  logic                            enq_epoch,
  input  logic [SSB_NUM_LD-1:0][AW-1:0]   ld_addr,
  input  logic [SSB_NUM_LD-1:0][BW-1:0]   ld_mask,
  output logic [SSB_NUM_LD-1:0]           ld_hit,
  output logic [SSB_NUM_LD-1:0]           ld_conflict,
  output logic [SSB_NUM_LD-1:0][DW-1:0]   ld_data,
  input  logic                            spec_join,
  input  logic                            spec_fail,
  output logic                            mem_valid,
  input  logic                            mem_ready,
  output logic [AW-1:0]                   mem_addr,
  output logic [DW-1:0]                   mem_data,
  output logic [BW-1:0]                   mem_mask,
  output logic                            full
);
  logic                     wr_en, flush, pop, draining;
  logic [CW-1:0]            cnt_w;
  logic [DEPTH-1:0]         ord_live, ord_epoch;
  logic [DEPTH-1:0][AW-1:0] ord_addr;
  logic [DEPTH-1:0][DW-1:0] ord_data;
  logic [DEPTH-1:0][BW-1:0] ord_mask;

  ssb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .join_i(spec_join), .fail_i(spec_fail),
    .enq_valid(enq_valid), .cnt(cnt_w), .pop(pop), .enq_ready(enq_ready),
    .wr_en(wr_en), .flush(flush), .draining(draining)
  );

  ssb_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(enq_addr),
    .wr_data(enq_data), .wr_mask(enq_mask), .wr_epoch(enq_epoch),
    .pop(pop), .flush(flush), .cnt(cnt_w), .ord_live(ord_live),
    .ord_addr(ord_addr), .ord_data(ord_data), .ord_mask(ord_mask),
    .ord_epoch(ord_epoch)
  );

  for (genvar p = 0; p < SSB_NUM_LD; p++) begin : g_ld
    ssb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .EPOCH(p)) u_fwd (
      .ord_live(ord_live), .ord_addr(ord_addr), .ord_data(ord_data),
      .ord_mask(ord_mask), .ord_epoch(ord_epoch), .q_addr(ld_addr[p]),
      .q_mask(ld_mask[p]), .hit(ld_hit[p]), .conflict(ld_conflict[p]),
      .data(ld_data[p])
    );
  end

  assign mem_valid = draining && ord_live[0];
  assign mem_addr  = ord_addr[0];
  assign mem_data  = ord_data[0];
  assign mem_mask  = ord_mask[0];
  assign pop       = mem_valid && mem_ready;
  assign full      = (cnt_w == CW'(DEPTH));
endmodule

// File: rtl/ssb_chk.sv
module ssb_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int BW   = DW / 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spec_join,
  input logic          spec_fail,
  input logic          enq_ready,
  input logic          full,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_data,
  input logic [BW-1:0] mem_mask,
  input logic [1:0]    ld_hit,
  input logic [1:0]    ld_conflict,
  input logic [CW-1:0] cnt
);
  // R2
  no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(spec_join));

  // R4
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                   && $stable(mem_data) && $stable(mem_mask)));

  // R5
  full_blocks_enq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !enq_ready);

  // R5
  drain_blocks_enq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !enq_ready);

  // R3
  fail_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_fail && !mem_valid) |=> (cnt == '0 && !mem_valid));

  // R9
  fail_ignored_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_fail && mem_valid && !mem_ready) |=> mem_valid);

  // R8
  hit_xor_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hit & ld_conflict) == 2'b00);

  // R6
  empty_no_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (ld_hit == 2'b00 && ld_conflict == 2'b00));
endmodule

bind spec_store_buf ssb_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .spec_join(spec_join), .spec_fail(spec_fail),
  .enq_ready(enq_ready), .full(full), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
  .mem_mask(mem_mask), .ld_hit(ld_hit), .ld_conflict(ld_conflict),
  .cnt(cnt_w)
);

// File: tb/spec_store_buf_bench.sv
`timescale 1ns/1ps
module spec_store_buf_bench;
  localparam int DEPTH = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [BW-1:0] m;
    logic          e;
  } ent_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid = 1'b0, enq_epoch = 1'b0;
  logic [AW-1:0] enq_addr = '0;
  logic [DW-1:0] enq_data = '0;
  logic [BW-1:0] enq_mask = '0;
  logic [1:0][AW-1:0] ld_addr = '0;
  logic [1:0][BW-1:0] ld_mask = '0;
  logic [1:0] ld_hit, ld_conflict;
  logic [1:0][DW-1:0] ld_data;
  logic spec_join = 1'b0, spec_fail = 1'b0;
  logic mem_valid, mem_ready = 1'b0, enq_ready, full;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic [BW-1:0] mem_mask;

  ent_t model[$];
  bit   exp_drain = 0;
  bit   rdy_en = 0;
  bit   done = 0;
  int   cyc = 0;
  int   nchk = 0, nfail = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #2.5 clk = ~clk;

  spec_store_buf u_spec_store_buf (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_addr(enq_addr), .enq_data(enq_data), .enq_mask(enq_mask),
    .enq_epoch(enq_epoch), .ld_addr(ld_addr), .ld_mask(ld_mask),
    .ld_hit(ld_hit), .ld_conflict(ld_conflict), .ld_data(ld_data),
    .spec_join(spec_join), .spec_fail(spec_fail), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_mask(mem_mask), .full(full)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= rdy_en && (cyc % 3 != 1);
  end

  // Monitor: every retired store must be the oldest committed one (R4, R2).
  always @(negedge clk) begin
    if (rst_n && mem_valid) begin
      if (!exp_drain) chk("R2 write without join", 1, 0);
      if (mem_ready) begin
        if (model.size() == 0) chk("R4 extra write", 1, 0);
        else begin
          chk("R4 addr", 64'(mem_addr), 64'(model[0].a));
          chk("R4 data", 64'(mem_data), 64'(model[0].d));
          chk("R4 mask", 64'(mem_mask), 64'(model[0].m));
          void'(model.pop_front());
          if (model.size() == 0) exp_drain = 0;
        end
      end
    end
  end

  task automatic enq(input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic [BW-1:0] m, input logic e, input bit exp_rdy);
    logic rdy;
    ent_t x;
    @(negedge clk);
    enq_valid = 1; enq_addr = a; enq_data = d; enq_mask = m; enq_epoch = e;
    #1 rdy = enq_ready;
    chk("R5 enq_ready", 64'(rdy), 64'(exp_rdy));
    @(posedge clk);
    if (rdy) begin
      x.a = a; x.d = d; x.m = m; x.e = e;
      model.push_back(x);
    end
    #1 enq_valid = 0;
  endtask

  task automatic look(input int p, input logic [AW-1:0] a, input logic [BW-1:0] m,
                      input string req);
    logic [BW-1:0] cov;
    logic [DW-1:0] md;
    logic eh, ec;
    @(negedge clk);
    ld_addr[p] = a; ld_mask[p] = m;
    #1;
    cov = '0; md = '0;
    foreach (model[k]) begin
      if (model[k].a == a && (p == 1 || model[k].e == 1'b0)) begin
        for (int b = 0; b < BW; b++)
          if (model[k].m[b] && m[b]) begin
            cov[b] = 1'b1;
            md[b*8 +: 8] = model[k].d[b*8 +: 8];
          end
      end
    end
    eh = (cov != 0) && (cov == m);
    ec = (cov != 0) && (cov != m);
    chk({req, " hit"}, 64'(ld_hit[p]), 64'(eh));
    chk({req, " conflict"}, 64'(ld_conflict[p]), 64'(ec));
    chk({req, " data"}, 64'(ld_data[p]), eh ? 64'(md) : 64'd0);
  endtask

  task automatic pulse(input bit j, input bit f);
    @(negedge clk);
    spec_join = j; spec_fail = f;
    @(posedge clk);
    #1;
    spec_join = 0; spec_fail = 0;
    if (!exp_drain) begin
      if (f) model.delete();
      else if (j && model.size() > 0) exp_drain = 1;
    end
  endtask

  task automatic wait_drain(input string req);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      #1;
      if (!mem_valid) break;
    end
    chk({req, " drain complete"}, 64'(model.size()), 0);
    chk({req, " mem_valid low"}, 64'(mem_valid), 0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 mem_valid", 64'(mem_valid), 0);
    chk("R1 full", 64'(full), 0);
    chk("R1 enq_ready", 64'(enq_ready), 1);
    look(0, 16'h0010, 4'hF, "R1 port0");
    look(1, 16'h0010, 4'hF, "R1 port1");

    // R6/R7/R8 forwarding by epoch and byte merge
    enq(16'h0010, 32'h1122_3344, 4'hF, 1'b0, 1);
    enq(16'h0020, 32'h5566_7788, 4'h3, 1'b1, 1);
    enq(16'h0010, 32'hAABB_CCDD, 4'hC, 1'b1, 1);
    look(0, 16'h0010, 4'hF, "R6 behind ignores ahead");
    look(1, 16'h0010, 4'hF, "R7 merged youngest bytes");
    look(0, 16'h0020, 4'h3, "R6 behind misses ahead-only");
    look(1, 16'h0020, 4'h3, "R6 ahead hit");
    look(1, 16'h0020, 4'hF, "R8 partial conflict");
    look(1, 16'h0030, 4'hF, "R8 no match");

    // R5 full and ignored enqueue
    enq(16'h0040, 32'h0BAD_F00D, 4'hF, 1'b0, 1);
    #1 chk("R5 full", 64'(full), 1);
    enq(16'h0050, 32'hDEAD_BEEF, 4'hF, 1'b0, 0);
    look(1, 16'h0050, 4'hF, "R5 refused store invisible");

    // R3 fail discards, join after fail writes nothing
    pulse(0, 1);
    #1 chk("R3 full after fail", 64'(full), 0);
    look(1, 16'h0010, 4'hF, "R3 discarded");
    pulse(1, 0);
    repeat (4) @(negedge clk);

    // R2 no write before join, then R4/R9/R10 drain with stall
    enq(16'h0100, 32'h0000_0001, 4'hF, 1'b0, 1);
    enq(16'h0101, 32'h0000_0002, 4'h1, 1'b1, 1);
    enq(16'h0102, 32'h0000_0003, 4'h8, 1'b0, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1 chk("R2 idle before join", 64'(mem_valid), 0);
    end
    pulse(1, 0);
    #1 chk("R4 drain started", 64'(mem_valid), 1);
    enq(16'h0200, 32'h1, 4'hF, 1'b0, 0);
    look(1, 16'h0101, 4'h1, "R6 visible during drain");
    pulse(0, 1);
    pulse(1, 0);
    #1 chk("R9 still draining", 64'(mem_valid), 1);
    rdy_en = 1;
    wait_drain("R9");
    chk("R10 enq_ready after drain", 64'(enq_ready), 1);

    // R3 join and fail together: fail wins
    enq(16'h0300, 32'h3333_0000, 4'hF, 1'b0, 1);
    enq(16'h0301, 32'h3333_0001, 4'hF, 1'b1, 1);
    pulse(1, 1);
    repeat (4) @(negedge clk);
    look(1, 16'h0300, 4'hF, "R3 fail beats join");

    // Rounds to wrap the pointers
    for (int r = 0; r < 8; r++) begin
      int n;
      n = 1 + (r % DEPTH);
      for (int i = 0; i < n; i++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        enq(16'h0400 + AW'(lfsr[1:0]), lfsr, (lfsr[7:4] == 0) ? 4'h1 : lfsr[7:4],
            lfsr[9], 1);
      end
      look(0, 16'h0400 + AW'(r % 4), 4'hF, "R7 round port0");
      look(1, 16'h0400 + AW'(r % 4), 4'h3, "R7 round port1");
      if (r == 5) begin
        pulse(0, 1);
        #1 chk("R3 round discarded", 64'(full), 0);
      end else begin
        pulse(1, 0);
        wait_drain("R4 round");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule